// File: doc/BRIEF.md
# Multiplier Host Register Interface

This block connects an 8-bit parallel host port to a shift-and-add multiplier datapath and its controller. The host writes two 32-bit operands one byte at a time, naming the operand and the byte lane with every write. When all eight byte lanes of both operands have been written, the block sends a single-cycle start pulse to the controller.

The block does not watch a done flag. It takes the controller's strobes: an A-update strobe, a B-update strobe, a shift strobe and a product-enable strobe. From these it derives the operand-enable controls and a result-update control. A multiplication has ended when that result-update control falls. At that edge the block copies the datapath's product into a readback register and sets a sticky completion flag. The host then reads the flag and the product bytes through a small read address space.

All outputs are registered. The reset is synchronous and active-high.

Top module: `mult_host_regs`

## Requirements
- R1: A host write stores `host_wdata` into one byte of one operand. `host_opnd` = 0 selects the first operand and 1 selects the second. `host_byte` = k selects bits [8k+7:8k], so byte 0 is the least significant. The other bytes of both operands keep their values.
- R2: `start` goes high for exactly one cycle. This happens in the cycle after the write that completes the set of all eight distinct (operand, byte) lanes written since reset or since the previous start. Rewriting a lane that is already written does not complete the set. After a start, tracking begins again from an empty set.
- R3: `opnd1_en` equals `upd_a` AND NOT `shift`, as sampled at the previous clock edge.
- R4: `opnd2_en` equals `upd_b` AND NOT `shift`, as sampled at the previous clock edge.
- R5: `result_upd` equals `en_p` as sampled at the previous clock edge.
- R6: At the edge where `result_upd` falls, `prod_in` is copied into the 32-bit readback register and the completion flag is set. While `en_p` stays high, no completion is reported and the readback register does not change.
- R7: The value read appears on `host_rdata` in the cycle after a read, and `host_rdata` holds its value when no read takes place. A read with `host_raddr` = k (0 to 3) returns byte k of the readback register, least significant byte first. A read with `host_raddr` = 4 returns the completion flag in bit 0, with zeros above it. A read with `host_raddr` of 5 to 7 returns zero.
- R8: A read at address 4 clears the completion flag. If a completion falls on the same edge as that read, the read returns the old value, 0, and the flag ends up set.
- R9: After reset, the following are all zero: both operands, `start`, the three derived controls, the readback register, the completion flag and `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_opnd | input | 1 | Operand select for a write (0 first, 1 second) |
| host_byte | input | 2 | Byte lane select for a write |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_raddr | input | 3 | Read address (0-3 product bytes, 4 status) |
| host_rdata | output | 8 | Registered read data |
| upd_a | input | 1 | Controller A-update strobe |
| upd_b | input | 1 | Controller B-update strobe |
| shift | input | 1 | Controller shift strobe |
| en_p | input | 1 | Controller product-enable strobe |
| prod_in | input | 32 | Product from the datapath |
| opnd_a | output | 32 | First operand register |
| opnd_b | output | 32 | Second operand register |
| start | output | 1 | One-cycle start pulse to the controller |
| opnd1_en | output | 1 | First operand enable |
| opnd2_en | output | 1 | Second operand enable |
| result_upd | output | 1 | Result-update control |

## Verification
Two events can fall on the same edge: the falling edge of `result_upd` and a host read of the status address. One sets the completion flag and the other clears it. The bench provokes this by dropping `en_p` in the same cycle that it issues the status read. The read must return 0, because it samples the flag before the set. A second status read must then return 1, which shows the set won, and a third read must return 0. The scoreboard queues each expected read byte when the read is issued and compares it when `host_rdata` updates.

// File: rtl/mhr_pkg.sv
`timescale 1ns/1ps
package mhr_pkg;
  typedef enum logic {
    OPND_FIRST  = 1'b0,
    OPND_SECOND = 1'b1
  } opnd_sel_e;
endpackage

// File: rtl/mhr_opnd_bank.sv
`timescale 1ns/1ps
module mhr_opnd_bank #(
  parameter int HOST_W = 8,
  parameter int OPND_W = 32,
  localparam int NB = OPND_W / HOST_W,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  mhr_pkg::opnd_sel_e sel,
  input  logic [BW-1:0]     bsel,
  input  logic [HOST_W-1:0] wdata,
  output logic [OPND_W-1:0] opnd_a,
  output logic [OPND_W-1:0] opnd_b,
  output logic              start
);
  localparam int MW = 2 * NB;

  logic [NB-1:0][HOST_W-1:0] lanes_a;
  logic [NB-1:0][HOST_W-1:0] lanes_b;
  logic [MW-1:0] seen_q;
  logic [MW-1:0] wbit;
  logic [MW-1:0] seen_nxt;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lanes_a[g] <= '0;
        lanes_b[g] <= '0;
      end else if (wr && bsel == BW'(g)) begin
        if (sel == mhr_pkg::OPND_FIRST) lanes_a[g] <= wdata;
        else                            lanes_b[g] <= wdata;
      end
    end
  end

  always_comb begin
    wbit = '0;
    if (wr) wbit[{sel, bsel}] = 1'b1;
    seen_nxt = seen_q | wbit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      start  <= 1'b0;
    end else if (&seen_nxt) begin
      seen_q <= '0;
      start  <= 1'b1;
    end else begin
      seen_q <= seen_nxt;
      start  <= 1'b0;
    end
  end

  assign opnd_a = lanes_a;
  assign opnd_b = lanes_b;
endmodule

// File: rtl/mhr_strobe_gate.sv
`timescale 1ns/1ps
module mhr_strobe_gate (
  input  logic clk,
  input  logic rst,
  input  logic upd_a,
  input  logic upd_b,
  input  logic shift,
  input  logic en_p,
  output logic opnd1_en,
  output logic opnd2_en,
  output logic result_upd,
  output logic fall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      opnd1_en   <= 1'b0;
      opnd2_en   <= 1'b0;
      result_upd <= 1'b0;
    end else begin
      opnd1_en   <= upd_a & ~shift;
      opnd2_en   <= upd_b & ~shift;
      result_upd <= en_p;
    end
  end

  // result_upd is about to drop at the coming edge
  assign fall = result_upd & ~en_p;
endmodule

// File: rtl/mhr_readback.sv
`timescale 1ns/1ps
module mhr_readback #(
  parameter int HOST_W = 8,
  parameter int OPND_W = 32,
  localparam int NB = OPND_W / HOST_W,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int AW = BW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic [OPND_W-1:0] prod_in,
  input  logic              rd,
  input  logic [AW-1:0]     raddr,
  output logic [HOST_W-1:0] rdata,
  output logic              done_flag,
  output logic [OPND_W-1:0] prod_hold
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NB);

  logic [NB-1:0][HOST_W-1:0] hold_lanes;
  logic [HOST_W-1:0] rd_mux;
  logic status_rd;

  assign prod_hold = hold_lanes;
  assign status_rd = rd && (raddr == STAT_ADDR);

  always_comb begin
    rd_mux = '0;
    if (raddr < STAT_ADDR)       rd_mux = hold_lanes[raddr[BW-1:0]];
    else if (raddr == STAT_ADDR) rd_mux = HOST_W'(done_flag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_lanes <= '0;
      done_flag  <= 1'b0;
      rdata      <= '0;
    end else begin
      if (fall) hold_lanes <= prod_in;
      if (fall)           done_flag <= 1'b1;
      else if (status_rd) done_flag <= 1'b0;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mult_host_regs.sv
`timescale 1ns/1ps
module mult_host_regs #(
  parameter int HOST_W = 8,
  parameter int OPND_W = 32,
  localparam int NB = OPND_W / HOST_W,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int AW = BW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_opnd,
  input  logic [BW-1:0]     host_byte,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic [AW-1:0]     host_raddr,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              upd_a,
  input  logic              upd_b,
  input  logic              shift,
  input  logic              en_p,
  input  logic [OPND_W-1:0] prod_in,
  output logic [OPND_W-1:0] opnd_a,
  output logic [OPND_W-1:0] opnd_b,
  output logic              start,
  output logic              opnd1_en,
  output logic              opnd2_en,
  output logic              result_upd
);
  logic fall;
  logic done_flag;
  logic [OPND_W-1:0] prod_hold;

  mhr_opnd_bank #(.HOST_W(HOST_W), .OPND_W(OPND_W)) u_bank (
    .clk(clk), .rst(rst), .wr(host_wr),
    .sel(mhr_pkg::opnd_sel_e'(host_opnd)), .bsel(host_byte),
    .wdata(host_wdata), .opnd_a(opnd_a), .opnd_b(opnd_b), .start(start)
  );

  mhr_strobe_gate u_gate (
    .clk(clk), .rst(rst), .upd_a(upd_a), .upd_b(upd_b), .shift(shift),
    .en_p(en_p), .opnd1_en(opnd1_en), .opnd2_en(opnd2_en),
    .result_upd(result_upd), .fall(fall)
  );

  mhr_readback #(.HOST_W(HOST_W), .OPND_W(OPND_W)) u_rb (
    .clk(clk), .rst(rst), .fall(fall), .prod_in(prod_in),
    .rd(host_rd), .raddr(host_raddr), .rdata(host_rdata),
    .done_flag(done_flag), .prod_hold(prod_hold)
  );
endmodule

// File: rtl/mult_host_regs_chk.sv
`timescale 1ns/1ps
module mult_host_regs_chk #(
  parameter int HOST_W = 8,
  parameter int OPND_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_rd,
  input logic [HOST_W-1:0] host_rdata,
  input logic              shift,
  input logic              en_p,
  input logic              start,
  input logic              opnd1_en,
  input logic              opnd2_en,
  input logic              result_upd,
  input logic              done_flag,
  input logic [OPND_W-1:0] prod_hold
);
  assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  assert_shift_blocks_a_R3: assert property (@(posedge clk) disable iff (rst)
    $past(shift) |-> !opnd1_en);

  assert_shift_blocks_b_R4: assert property (@(posedge clk) disable iff (rst)
    $past(shift) |-> !opnd2_en);

  assert_result_follows_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(result_upd) |-> $past(en_p));

  assert_fall_sets_done_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(result_upd) |-> done_flag);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !$fell(result_upd) |-> $stable(prod_hold));

  assert_rdata_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(host_rd) |-> $stable(host_rdata));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !host_rd) |=> done_flag);
endmodule

bind mult_host_regs mult_host_regs_chk #(.HOST_W(HOST_W), .OPND_W(OPND_W)) u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_rdata(host_rdata),
  .shift(shift), .en_p(en_p), .start(start), .opnd1_en(opnd1_en),
  .opnd2_en(opnd2_en), .result_upd(result_upd), .done_flag(done_flag),
  .prod_hold(prod_hold)
);

// File: tb/mult_host_regs_test.sv
`timescale 1ns/1ps
module mult_host_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_opnd = 1'b0, host_rd = 1'b0;
  logic [1:0] host_byte = '0;
  logic [7:0] host_wdata = '0;
  logic [2:0] host_raddr = '0;
  logic [7:0] host_rdata;
  logic upd_a = 1'b0, upd_b = 1'b0, shift = 1'b0, en_p = 1'b0;
  logic [31:0] prod_in = '0;
  logic [31:0] opnd_a, opnd_b;
  logic start, opnd1_en, opnd2_en, result_upd;

  int checks = 0;
  int failures = 0;
  int start_cnt = 0;
  bit finished = 1'b0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  mult_host_regs uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_opnd(host_opnd),
    .host_byte(host_byte), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_raddr(host_raddr), .host_rdata(host_rdata), .upd_a(upd_a),
    .upd_b(upd_b), .shift(shift), .en_p(en_p), .prod_in(prod_in),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .start(start), .opnd1_en(opnd1_en),
    .opnd2_en(opnd2_en), .result_upd(result_upd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares read data the cycle after a read edge
  always @(posedge clk) rd_seen <= host_rd & ~rst;
  always @(negedge clk) begin
    if (start) start_cnt++;
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R7 unexpected read", 32'h1, 32'h0);
      else check(tag_q.pop_front(), {24'h0, host_rdata}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic host_write(input logic sel, input logic [1:0] b, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_opnd = sel; host_byte = b; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_rd = 1'b1; host_raddr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 start", {31'h0, start}, 32'h0);
    check("R9 opnd_a", opnd_a, 32'h0);
    check("R9 opnd_b", opnd_b, 32'h0);
    check("R9 enables", {29'h0, opnd1_en, opnd2_en, result_upd}, 32'h0);
    host_read(3'd4, 8'h00, "R9 status");
    host_read(3'd0, 8'h00, "R9 product byte");

    // R1 little-endian operand loading
    host_write(1'b0, 2'd0, 8'h11);
    host_write(1'b0, 2'd1, 8'h22);
    host_write(1'b0, 2'd2, 8'h33);
    host_write(1'b0, 2'd3, 8'h44);
    check("R1 opnd_a", opnd_a, 32'h44332211);
    check("R1 opnd_b untouched", opnd_b, 32'h0);
    check("R2 no early start", start_cnt, 0);

    // R2 rewrite does not complete the set
    host_write(1'b1, 2'd2, 8'hC3);
    host_write(1'b1, 2'd0, 8'hA1);
    host_write(1'b1, 2'd2, 8'hC4);
    host_write(1'b1, 2'd3, 8'hD5);
    check("R2 rewrite no start", start_cnt, 0);
    host_write(1'b1, 2'd1, 8'hB2);
    check("R2 start high", {31'h0, start}, 32'h1);
    check("R1 opnd_b", opnd_b, 32'hD5C4B2A1);
    @(negedge clk);
    check("R2 start one cycle", {31'h0, start}, 32'h0);
    check("R2 single pulse", start_cnt, 1);
    host_write(1'b0, 2'd0, 8'h99);
    check("R1 byte rewrite", opnd_a, 32'h44332299);
    check("R2 tracking restarted", start_cnt, 1);

    // R3 / R4 gating
    upd_a = 1'b1;
    @(negedge clk);
    check("R3 enable", {31'h0, opnd1_en}, 32'h1);
    check("R4 idle", {31'h0, opnd2_en}, 32'h0);
    upd_b = 1'b1; shift = 1'b1;
    @(negedge clk);
    check("R3 shift blocks", {31'h0, opnd1_en}, 32'h0);
    check("R4 shift blocks", {31'h0, opnd2_en}, 32'h0);
    upd_a = 1'b0; shift = 1'b0;
    @(negedge clk);
    check("R4 enable", {31'h0, opnd2_en}, 32'h1);
    check("R3 idle", {31'h0, opnd1_en}, 32'h0);
    upd_b = 1'b0;

    // R5 / R6 completion by falling edge
    en_p = 1'b1; prod_in = 32'h12345678;
    @(negedge clk);
    check("R5 follows en_p", {31'h0, result_upd}, 32'h1);
    prod_in = 32'hDEADBEEF;
    @(negedge clk);
    en_p = 1'b0;
    @(negedge clk);
    check("R5 drops", {31'h0, result_upd}, 32'h0);
    prod_in = 32'h0BADF00D;
    host_read(3'd4, 8'h01, "R6 done set");
    host_read(3'd4, 8'h00, "R8 read clears");
    host_read(3'd0, 8'hEF, "R7 byte0");
    host_read(3'd1, 8'hBE, "R7 byte1");
    host_read(3'd2, 8'hAD, "R7 byte2");
    host_read(3'd3, 8'hDE, "R7 byte3");
    host_read(3'd5, 8'h00, "R7 unused address");

    // R6 product-enable held high: no completion
    en_p = 1'b1; prod_in = 32'h55AA55AA;
    repeat (5) @(negedge clk);
    host_read(3'd4, 8'h00, "R6 no completion");
    host_read(3'd0, 8'hEF, "R6 hold unchanged");

    // R8 collision: fall and status read on the same edge
    @(negedge clk);
    en_p = 1'b0; host_rd = 1'b1; host_raddr = 3'd4;
    exp_q.push_back(8'h00); tag_q.push_back("R8 collision read old");
    @(negedge clk);
    host_rd = 1'b0;
    host_read(3'd4, 8'h01, "R8 set wins");
    host_read(3'd3, 8'h55, "R6 new capture");
    host_read(3'd4, 8'h00, "R8 cleared after");
    @(negedge clk);
    check("R7 queue drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule